// File: doc/BRIEF.md
# Dual-Strobe DRAM Cycle Classifier

This block watches the active-low control pins of a 16-bit asynchronous DRAM from a fast synchronous clock. The pins are row strobe, upper and lower column strobes, write enable and output enable. For every period in which the row strobe is low, it works out which kind of access took place and which byte lanes took part. It reports the result as a single-cycle pulse once the row strobe returns high. While the access is running, it also gives a per-lane flag that shows when that lane would be driving the data pins.

The access mode follows the combined effect of the two column strobes. The mode starts at the first falling strobe and ends at the last rising one. Write and output-drive decisions are made separately for each lane. Every pin first passes through a two-flop synchronizer. All edges are then judged against each other on the same synchronized sample, so "at or before" means "on the same sample or earlier".

Top module: `dram_cycle_monitor`

## Requirements
- R1: After reset, and whenever the row strobe is high, `cycleValid` is 0 and `driveEn` is 2'b00.
- R2: If either column strobe is low on the sample where the row strobe falls, the access is reported as type 6 (CBR refresh) with `laneMask` 2'b00. This holds even when the other strobe is high.
- R3: If the row strobe falls with both column strobes high and neither goes low before it rises, the access is reported as type 5 (row-only refresh) with `laneMask` 2'b00.
- R4: If write enable is low on or before the sample of the first column-strobe fall, the access is type 1 (early write), and `driveEn` stays 2'b00 for the whole access.
- R5: If write enable falls after the first column-strobe fall, and no output-enabled read was seen before it, the access is type 2 (delayed write).
- R6: If output enable was low with write enable high while a column strobe was low, and write enable then falls while a column strobe is still low, the access is type 3 (read-modify-write).
- R7: A column access with no write is type 0 (read) if output enable was low during it, and type 4 (read, outputs disabled) if output enable stayed high.
- R8: `laneMask` bit 0 marks the lower lane (`lcasN`) and bit 1 the upper lane (`ucasN`). A bit is set if its strobe was low at any point during the access.
- R9: `driveEn[i]` is 1 only while the row strobe, lane i's own column strobe and output enable are all low, and no write has started on lane i in this access. It follows the pins with a latency of three clock cycles.
- R10: Exactly one `cycleValid` pulse, one cycle long, follows each rise of the row strobe. `cycleType` uses the 3-bit codes given in R2 to R7 and never takes the value 7.
- R11: The write-timing reference is the earliest column-strobe fall. Write enable falling between the two strobe falls gives type 2, while write enable low before the first fall gives type 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasN | input | 1 | Row strobe pin, active low, asynchronous |
| ucasN | input | 1 | Upper-lane column strobe, active low |
| lcasN | input | 1 | Lower-lane column strobe, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| cycleValid | output | 1 | One-cycle pulse carrying an access report |
| cycleType | output | 3 | Access type code, valid with `cycleValid` |
| laneMask | output | 2 | Lanes used in the access, valid with `cycleValid` |
| driveEn | output | 2 | Per-lane output-drive flag |

## Verification
The hardest cases to reach are those that depend only on the relative order of edges: write enable falling between two staggered column-strobe falls, and a read that turns into a read-modify-write. The directed tasks change one pin at a time and then wait several clock cycles. Each edge therefore lands on its own synchronized sample, which pins down exactly which edge the classifier saw first. The single-strobe refresh case is set up the same way, with only one column strobe lowered before the row strobe.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  typedef enum logic [2:0] {
    TYPE_READ        = 3'd0,
    TYPE_EARLY_WRITE = 3'd1,
    TYPE_DELAY_WRITE = 3'd2,
    TYPE_RMW         = 3'd3,
    TYPE_READ_NO_OUT = 3'd4,
    TYPE_ROW_REFRESH = 3'd5,
    TYPE_CBR_REFRESH = 3'd6
  } cycleType_t;

  typedef struct packed {
    logic       clearCycle;
    logic       track;
    logic       report;
    cycleType_t typeCode;
  } ctlStrobe_t;

endpackage

// File: rtl/dcm_sync.sv
module dcm_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] pinsOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rstN) chain[s] <= '1;
        else if (s == 0) chain[s] <= pinsIn;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinsOut = chain[STAGES-1];
endmodule

// File: rtl/dcm_ctrl.sv
module dcm_ctrl
  import dcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasS,
  input  logic       ucasS,
  input  logic       lcasS,
  input  logic       weS,
  input  logic       oeS,
  output ctlStrobe_t strobe,
  output logic       inCycle,
  output logic       weEarly
);
  logic prevRas, prevCasAny;
  logic cbrFlag, casSeen, weLate, readDriven, rmwFlag;
  logic rasFall, rasRise, casAny, casFall;
  cycleType_t typeNext;

  assign rasFall = prevRas & ~rasS;
  assign rasRise = ~prevRas & rasS;
  assign casAny  = ~ucasS | ~lcasS;
  assign casFall = casAny & ~prevCasAny;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevRas    <= 1'b1;
      prevCasAny <= 1'b0;
      inCycle    <= 1'b0;
      cbrFlag    <= 1'b0;
      casSeen    <= 1'b0;
      weEarly    <= 1'b0;
      weLate     <= 1'b0;
      readDriven <= 1'b0;
      rmwFlag    <= 1'b0;
    end else begin
      prevRas    <= rasS;
      prevCasAny <= casAny;
      if (rasFall) begin
        inCycle    <= 1'b1;
        cbrFlag    <= casAny;
        casSeen    <= 1'b0;
        weEarly    <= 1'b0;
        weLate     <= 1'b0;
        readDriven <= 1'b0;
        rmwFlag    <= 1'b0;
      end else if (inCycle) begin
        if (rasRise) inCycle <= 1'b0;
        if (!cbrFlag) begin
          if (casFall && !casSeen) begin
            casSeen <= 1'b1;
            weEarly <= ~weS;
          end
          if (casSeen && casAny && !weEarly && !weLate && !weS) begin
            weLate  <= 1'b1;
            rmwFlag <= readDriven;
          end
          if (casAny && weS && !oeS && !weLate && !weEarly)
            readDriven <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    if (cbrFlag)         typeNext = TYPE_CBR_REFRESH;
    else if (!casSeen)   typeNext = TYPE_ROW_REFRESH;
    else if (weEarly)    typeNext = TYPE_EARLY_WRITE;
    else if (weLate)     typeNext = rmwFlag ? TYPE_RMW : TYPE_DELAY_WRITE;
    else if (readDriven) typeNext = TYPE_READ;
    else                 typeNext = TYPE_READ_NO_OUT;
  end

  assign strobe.clearCycle = rasFall;
  assign strobe.track      = inCycle & ~cbrFlag & ~rasRise;
  assign strobe.report     = inCycle & rasRise;
  assign strobe.typeCode   = typeNext;

  // R4 / R5: the two write timings exclude each other
  assert_write_kind_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(weEarly && weLate));

  // R6: read-modify-write only follows an output-enabled read
  assert_rmw_needs_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    rmwFlag |-> readDriven);
endmodule

// File: rtl/dcm_datapath.sv
module dcm_datapath
  import dcm_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [LANES-1:0] casLow,
  input  logic             weS,
  input  logic             oeS,
  output logic             cycleValid,
  output logic [2:0]       cycleType,
  output logic [LANES-1:0] laneMask,
  output logic [LANES-1:0] driveEn
);
  logic [LANES-1:0] laneAcc, laneWrite, writeNow;

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign writeNow[i] = laneWrite[i] | (~weS & casLow[i]);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          laneAcc[i]   <= 1'b0;
          laneWrite[i] <= 1'b0;
          driveEn[i]   <= 1'b0;
        end else begin
          if (strobe.clearCycle) begin
            laneAcc[i]   <= 1'b0;
            laneWrite[i] <= 1'b0;
          end else if (strobe.track) begin
            laneAcc[i]   <= laneAcc[i] | casLow[i];
            laneWrite[i] <= writeNow[i];
          end
          driveEn[i] <= strobe.track & casLow[i] & ~oeS & ~writeNow[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycleValid <= 1'b0;
      cycleType  <= 3'd0;
      laneMask   <= '0;
    end else begin
      cycleValid <= strobe.report;
      if (strobe.report) begin
        cycleType <= strobe.typeCode;
        laneMask  <= laneAcc;
      end
    end
  end

  // R9: a lane drives only during a tracked access
  assert_drive_in_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|driveEn) |-> $past(strobe.track));

  // R2: refresh reports carry no lanes
  assert_cbr_no_lanes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && cycleType == TYPE_CBR_REFRESH) |-> (laneMask == '0));
endmodule

// File: rtl/dram_cycle_monitor.sv
module dram_cycle_monitor
  import dcm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rasN,
  input  logic       ucasN,
  input  logic       lcasN,
  input  logic       weN,
  input  logic       oeN,
  output logic       cycleValid,
  output logic [2:0] cycleType,
  output logic [1:0] laneMask,
  output logic [1:0] driveEn
);
  localparam int PIN_COUNT = 5;

  logic [PIN_COUNT-1:0] pinsSync;
  ctlStrobe_t strobe;
  logic inCycle, weEarly;

  dcm_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN),
    .pinsIn({oeN, weN, lcasN, ucasN, rasN}),
    .pinsOut(pinsSync)
  );

  dcm_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rasS(pinsSync[0]), .ucasS(pinsSync[1]), .lcasS(pinsSync[2]),
    .weS(pinsSync[3]), .oeS(pinsSync[4]),
    .strobe(strobe), .inCycle(inCycle), .weEarly(weEarly)
  );

  dcm_datapath #(.LANES(2)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .casLow({~pinsSync[1], ~pinsSync[2]}),
    .weS(pinsSync[3]), .oeS(pinsSync[4]),
    .cycleValid(cycleValid), .cycleType(cycleType),
    .laneMask(laneMask), .driveEn(driveEn)
  );

  // R10: report is a single-cycle pulse
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |=> !cycleValid);

  // R10: code 7 is never reported
  assert_type_legal_R10: assert property (@(posedge clk) disable iff (!rstN)
    cycleValid |-> (cycleType != 3'd7));

  // R4: an early write never lets a lane drive
  assert_early_no_drive_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inCycle && $past(weEarly) && weEarly) |-> (driveEn == 2'b00));
endmodule

// File: tb/dram_cycle_monitor_test.sv
module dram_cycle_monitor_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1, ucasN = 1'b1, lcasN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic cycleValid;
  logic [2:0] cycleType;
  logic [1:0] laneMask, driveEn;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dram_cycle_monitor uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .ucasN(ucasN), .lcasN(lcasN),
    .weN(weN), .oeN(oeN), .cycleValid(cycleValid), .cycleType(cycleType),
    .laneMask(laneMask), .driveEn(driveEn)
  );

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic endCycle(input string req, input int expType, input int expMask);
    int pulses = 0;
    int gotType = -1, gotMask = -1;
    ucasN = 1'b1; lcasN = 1'b1; oeN = 1'b1; weN = 1'b1;
    step(3);
    rasN = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(1);
      if (cycleValid) begin
        pulses++;
        gotType = cycleType;
        gotMask = laneMask;
      end
    end
    check("R10 pulse count", pulses, 1);
    check({req, " type"}, gotType, expType);
    check("R8 lane mask", gotMask, expMask);
    check("R1 idle drive", driveEn, 0);
    step(3);
  endtask

  task automatic tReset();
    check("R1 reset valid", cycleValid, 0);
    check("R1 reset drive", driveEn, 0);
  endtask

  task automatic tWordRead();
    rasN = 0; step(3);
    lcasN = 0; ucasN = 0; oeN = 0; step(4);
    check("R9 word read drive", driveEn, 3);
    endCycle("R7 read", 0, 3);
  endtask

  task automatic tLowerReadNoOut();
    rasN = 0; step(3);
    lcasN = 0; step(4);
    check("R9 oe high drive", driveEn, 0);
    endCycle("R7 read no out", 4, 1);
  endtask

  task automatic tUpperEarlyWrite();
    weN = 0; step(3);
    rasN = 0; step(3);
    ucasN = 0; oeN = 0; step(4);
    check("R4 early write drive", driveEn, 0);
    endCycle("R4 early write", 1, 2);
  endtask

  task automatic tWordDelayedWrite();
    rasN = 0; step(3);
    lcasN = 0; ucasN = 0; step(3);
    weN = 0; step(3);
    endCycle("R5 delayed write", 2, 3);
  endtask

  task automatic tUpperRmw();
    rasN = 0; step(3);
    ucasN = 0; oeN = 0; step(4);
    check("R9 rmw read drive", driveEn, 2);
    weN = 0; step(4);
    check("R9 rmw write drive", driveEn, 0);
    endCycle("R6 rmw", 3, 2);
  endtask

  task automatic tRowRefresh();
    rasN = 0; step(6);
    check("R3 refresh drive", driveEn, 0);
    endCycle("R3 row refresh", 5, 0);
  endtask

  task automatic tCbr(input bit upper);
    if (upper) ucasN = 0; else lcasN = 0;
    oeN = 0;
    step(3);
    rasN = 0; step(4);
    check("R2 cbr drive", driveEn, 0);
    endCycle("R2 cbr", 6, 0);
  endtask

  task automatic tStaggerDelayed();
    rasN = 0; step(3);
    lcasN = 0; step(3);
    weN = 0; step(3);
    ucasN = 0; step(3);
    endCycle("R11 staggered delayed", 2, 3);
  endtask

  task automatic tStaggerEarly();
    weN = 0; step(3);
    rasN = 0; step(3);
    lcasN = 0; step(3);
    ucasN = 0; step(3);
    endCycle("R11 staggered early", 1, 3);
  endtask

  initial begin
    step(4);
    rstN = 1'b1;
    step(2);
    tReset();
    tWordRead();
    tLowerReadNoOut();
    tUpperEarlyWrite();
    tWordDelayedWrite();
    tUpperRmw();
    tRowRefresh();
    tCbr(1'b0);
    tCbr(1'b1);
    tStaggerDelayed();
    tStaggerEarly();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule